// File: doc/BRIEF.md
# Ethernet PHY Serial Management Register Slave

This block is the management-side register slave of an Ethernet PHY. It watches the two-wire management bus (clock MDC, bidirectional data MDIO) and decodes standard Clause 22 read and write frames. It holds a small register set: a basic control word, a basic status word, the advertisement word, a live status mirror and an auxiliary control word. From these it drives the PHY's control pins: loopback enable, auto-negotiation enable and restart, the forced or negotiated speed and duplex, and the MDIX crossover controls. It also drives two speed LEDs.

MDC and MDIO are brought into the system clock domain through synchronisers, and each bit is taken on a rising MDC edge. A frame is accepted only when it follows an unbroken preamble of ones. Its 5-bit PHY address must match the `phy_addr` input. For a read, the slave takes the line during the second turnaround bit and the 16 data bits and releases it otherwise. A 3-bit strap picks the reset values of the control word. The advertisement word given to the negotiation logic is refreshed only at reset and at a negotiation restart.

The block has no streaming data path. All pins are plain level or pulse signals, and the management bus keeps its own bit-serial timing.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: A read frame (start 01, opcode 10) with a matching PHY address returns the register MSB first, one bit per rising MDC edge, after the turnaround. The slave drives 0 in the second turnaround bit and drives the line (`mdio_oe`=1) only in that bit and the 16 data bits.
- R2: A frame whose PHY address differs from `phy_addr` is ignored. The line is never driven and no register changes.
- R3: Control bit 12 (register 0) enables negotiation. While it is 1, `cur_speed100`/`cur_full` follow `neg_speed100`/`neg_full`, and control bits 13 and 8 have no effect. While it is 0, bit 13 (1 = 100 Mb/s) and bit 8 (1 = full duplex) set them.
- R4: Writing 1 to control bit 9 gives exactly one `aneg_restart` pulse of one clock. The bit always reads back 0.
- R5: Control bit 14 drives `loopback_en`.
- R6: Status register 1 bit 2 is latching-low. After reset or after any cycle with `link_up`=0, it reads 0 until register 1 is read once. The following read shows the current link.
- R7: Register 0x11 is read-only and live. Bit 2 is `link_up`, bit 1 is the current speed (1 = 100) and bit 3 is the current duplex (1 = full). All other bits are 0.
- R8: Register 4 reads back as written and resets to `ADV_RESET`. `adv_word` takes the register-4 value only at reset and when a restart is written; other writes leave it unchanged.
- R9: Register 0x12 bit 15 enables automatic MDIX (reset value 1). Bit 14 selects crossover (reset value 0). They drive `mdix_auto` and `mdix_cross`.
- R10: `led_100` is `link_up` AND current speed 100. `led_10` is `link_up` AND current speed 10. This holds for forced and negotiated speed alike.
- R11: At reset, `strap` sets control bits 12, 13 and 8. Codes 000 (10 half), 010 (100 half), 100 (10 full) and 110 (100 full) force the mode. Any code with bit 0 set enables negotiation. Strap bit 1 gives speed and strap bit 2 gives duplex.
- R12: Addresses other than 0, 1, 4, 0x11 and 0x12 read as zero and ignore writes. Writes to registers 1 and 0x11 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phy_addr | input | 5 | PHY address this slave answers to |
| strap | input | 3 | Reset mode strap |
| mdc | input | 1 | Management clock from the station |
| mdio_in | input | 1 | Management data line as seen by the pad |
| mdio_out | output | 1 | Data driven by the slave |
| mdio_oe | output | 1 | Drive enable for `mdio_out` |
| link_up | input | 1 | Live link indication |
| neg_speed100 | input | 1 | Negotiated speed, 1 = 100 Mb/s |
| neg_full | input | 1 | Negotiated duplex, 1 = full |
| loopback_en | output | 1 | Loopback enable |
| aneg_enable | output | 1 | Auto-negotiation enable |
| aneg_restart | output | 1 | One-clock negotiation restart pulse |
| adv_word | output | 16 | Advertisement word for the link code word |
| cur_speed100 | output | 1 | Operating speed, 1 = 100 Mb/s |
| cur_full | output | 1 | Operating duplex, 1 = full |
| mdix_auto | output | 1 | Automatic crossover enable |
| mdix_cross | output | 1 | Manual crossover select |
| led_10 | output | 1 | 10 Mb/s link LED |
| led_100 | output | 1 | 100 Mb/s link LED |

## Verification
A rising MDC edge is seen `SYNC_STAGES`+1 clocks after it happens, so slave line changes follow each edge by about three clocks. The station samples read bits on the next rising MDC edge, a full MDC period later, which leaves a wide margin. Register effects (control pins, `adv_word`, the restart pulse) appear two clocks after the final data edge is seen. The bench therefore suspends its every-clock comparison while a frame is in flight and for twelve clocks after it. The LEDs and current speed and duplex react to the input pins combinationally, so they are compared in the same cycle. Inputs are changed one time unit after a falling clock edge and outputs are sampled on falling edges.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

  // register addresses
  localparam logic [4:0] RA_CTRL = 5'h00;
  localparam logic [4:0] RA_STAT = 5'h01;
  localparam logic [4:0] RA_ADV  = 5'h04;
  localparam logic [4:0] RA_LIVE = 5'h11;
  localparam logic [4:0] RA_AUX  = 5'h12;

  // control word bit positions
  localparam int CB_LOOP = 14;
  localparam int CB_SPD  = 13;
  localparam int CB_ANEN = 12;
  localparam int CB_RSTA = 9;
  localparam int CB_DUP  = 8;

  typedef enum logic [2:0] {
    FS_PRE,
    FS_ST,
    FS_HDR,
    FS_TA,
    FS_DATA
  } frame_state_t;

  typedef struct packed {
    logic loop;
    logic spd;
    logic anen;
    logic dup;
  } ctl_t;

  function automatic ctl_t strap_ctl(input logic [2:0] s);
    ctl_t c;
    c.loop = 1'b0;
    c.anen = s[0];
    c.spd  = s[1];
    c.dup  = s[2];
    return c;
  endfunction

endpackage

// File: rtl/mdio_bit_sampler.sv
module mdio_bit_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mdc,
  input  logic mdio,
  output logic bit_stb,
  output logic bit_val
);
  logic [STAGES:0]   mdc_q;
  logic [STAGES-1:0] dat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mdc_q <= '0;
      dat_q <= '1;
    end else begin
      mdc_q <= {mdc_q[STAGES-1:0], mdc};
      dat_q <= {dat_q[STAGES-2:0], mdio};
    end
  end

  // data travels through the same depth as the clock, so it is aligned with the edge
  assign bit_stb = mdc_q[STAGES-1] & ~mdc_q[STAGES];
  assign bit_val = dat_q[STAGES-1];
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_BITS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_stb,
  input  logic        bit_val,
  input  logic [4:0]  phy_addr,
  input  logic [15:0] rd_data,
  output logic        rd_req,
  output logic        wr_req,
  output logic [4:0]  reg_addr,
  output logic [15:0] wr_data,
  output logic        mdio_out,
  output logic        mdio_oe
);
  localparam int MAXC  = (PRE_BITS > 16) ? PRE_BITS : 16;
  localparam int CNT_W = $clog2(MAXC + 1);

  frame_state_t     st;
  logic [CNT_W-1:0] cnt;
  logic [10:0]      hdr;
  logic [11:0]      nxt_hdr;
  logic [15:0]      shreg;
  logic             is_rd;
  logic             op_rd, op_wr, phy_ok;

  assign nxt_hdr = {hdr, bit_val};
  assign op_rd   = (nxt_hdr[11:10] == 2'b10);
  assign op_wr   = (nxt_hdr[11:10] == 2'b01);
  assign phy_ok  = (nxt_hdr[9:5] == phy_addr);

  assign reg_addr = hdr[4:0];
  assign wr_data  = {shreg[14:0], bit_val};
  assign rd_req   = bit_stb && (st == FS_TA) && (cnt == '0) && is_rd;
  assign wr_req   = bit_stb && (st == FS_DATA) && (cnt == CNT_W'(15)) && !is_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= FS_PRE;
      cnt      <= '0;
      hdr      <= '0;
      shreg    <= '0;
      is_rd    <= 1'b0;
      mdio_oe  <= 1'b0;
      mdio_out <= 1'b1;
    end else if (bit_stb) begin
      case (st)
        FS_PRE: begin
          if (bit_val) begin
            if (cnt < CNT_W'(PRE_BITS)) cnt <= cnt + 1'b1;
          end else if (cnt == CNT_W'(PRE_BITS)) begin
            st  <= FS_ST;
            cnt <= '0;
          end else begin
            cnt <= '0;
          end
        end
        FS_ST: begin
          cnt <= '0;
          st  <= bit_val ? FS_HDR : FS_PRE;
        end
        FS_HDR: begin
          hdr <= nxt_hdr[10:0];
          if (cnt == CNT_W'(11)) begin
            cnt <= '0;
            if ((op_rd || op_wr) && phy_ok) begin
              st    <= FS_TA;
              is_rd <= op_rd;
            end else begin
              st <= FS_PRE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        FS_TA: begin
          if (cnt == '0) begin
            cnt <= CNT_W'(1);
            if (is_rd) begin
              mdio_oe  <= 1'b1;
              mdio_out <= 1'b0;
              shreg    <= rd_data;
            end
          end else begin
            cnt <= '0;
            st  <= FS_DATA;
            if (is_rd) begin
              mdio_out <= shreg[15];
              shreg    <= {shreg[14:0], 1'b0};
            end
          end
        end
        FS_DATA: begin
          if (is_rd) begin
            mdio_out <= shreg[15];
            shreg    <= {shreg[14:0], 1'b0};
          end else begin
            shreg <= {shreg[14:0], bit_val};
          end
          if (cnt == CNT_W'(15)) begin
            st       <= FS_PRE;
            cnt      <= '0;
            mdio_oe  <= 1'b0;
            mdio_out <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          st  <= FS_PRE;
          cnt <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank
  import mdio_mgmt_pkg::*;
#(
  parameter logic [15:0] ADV_RESET = 16'h01E1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  strap,
  input  logic        rd_req,
  input  logic        wr_req,
  input  logic [4:0]  reg_addr,
  input  logic [15:0] wr_data,
  input  logic        link_up,
  input  logic        neg_speed100,
  input  logic        neg_full,
  output logic [15:0] rd_data,
  output logic        loopback_en,
  output logic        aneg_enable,
  output logic        aneg_restart,
  output logic [15:0] adv_word,
  output logic        cur_speed100,
  output logic        cur_full,
  output logic        mdix_auto,
  output logic        mdix_cross
);
  ctl_t        ctl;
  logic [15:0] anar;
  logic        lat_link;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl          <= strap_ctl(strap);
      anar         <= ADV_RESET;
      adv_word     <= ADV_RESET;
      lat_link     <= 1'b0;
      mdix_auto    <= 1'b1;
      mdix_cross   <= 1'b0;
      aneg_restart <= 1'b0;
    end else begin
      aneg_restart <= 1'b0;
      if (wr_req) begin
        case (reg_addr)
          RA_CTRL: begin
            ctl.loop     <= wr_data[CB_LOOP];
            ctl.spd      <= wr_data[CB_SPD];
            ctl.anen     <= wr_data[CB_ANEN];
            ctl.dup      <= wr_data[CB_DUP];
            aneg_restart <= wr_data[CB_RSTA];
            if (wr_data[CB_RSTA]) adv_word <= anar;
          end
          RA_ADV: anar <= wr_data;
          RA_AUX: begin
            mdix_auto  <= wr_data[15];
            mdix_cross <= wr_data[14];
          end
          default: ;
        endcase
      end
      if (!link_up)
        lat_link <= 1'b0;
      else if (rd_req && (reg_addr == RA_STAT))
        lat_link <= 1'b1;
    end
  end

  assign loopback_en  = ctl.loop;
  assign aneg_enable  = ctl.anen;
  assign cur_speed100 = ctl.anen ? neg_speed100 : ctl.spd;
  assign cur_full     = ctl.anen ? neg_full : ctl.dup;

  always_comb begin
    case (reg_addr)
      RA_CTRL: rd_data = {1'b0, ctl.loop, ctl.spd, ctl.anen, 3'b000, ctl.dup, 8'h00};
      RA_STAT: rd_data = {13'h0000, lat_link, 2'b00};
      RA_ADV:  rd_data = anar;
      RA_LIVE: rd_data = {12'h000, cur_full, link_up, cur_speed100, 1'b0};
      RA_AUX:  rd_data = {mdix_auto, mdix_cross, 14'h0000};
      default: rd_data = 16'h0000;
    endcase
  end
endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
  import mdio_mgmt_pkg::*;
#(
  parameter int          PRE_BITS    = 32,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] ADV_RESET   = 16'h01E1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  phy_addr,
  input  logic [2:0]  strap,
  input  logic        mdc,
  input  logic        mdio_in,
  output logic        mdio_out,
  output logic        mdio_oe,
  input  logic        link_up,
  input  logic        neg_speed100,
  input  logic        neg_full,
  output logic        loopback_en,
  output logic        aneg_enable,
  output logic        aneg_restart,
  output logic [15:0] adv_word,
  output logic        cur_speed100,
  output logic        cur_full,
  output logic        mdix_auto,
  output logic        mdix_cross,
  output logic        led_10,
  output logic        led_100
);
  logic        bit_stb, bit_val;
  logic        rd_req, wr_req;
  logic [4:0]  reg_addr;
  logic [15:0] wr_data, rd_data;

  mdio_bit_sampler #(.STAGES(SYNC_STAGES)) u_samp (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio(mdio_in),
    .bit_stb(bit_stb), .bit_val(bit_val)
  );

  mdio_frame_engine #(.PRE_BITS(PRE_BITS)) u_eng (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(bit_val),
    .phy_addr(phy_addr), .rd_data(rd_data), .rd_req(rd_req), .wr_req(wr_req),
    .reg_addr(reg_addr), .wr_data(wr_data), .mdio_out(mdio_out), .mdio_oe(mdio_oe)
  );

  mdio_reg_bank #(.ADV_RESET(ADV_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .strap(strap), .rd_req(rd_req), .wr_req(wr_req),
    .reg_addr(reg_addr), .wr_data(wr_data), .link_up(link_up),
    .neg_speed100(neg_speed100), .neg_full(neg_full), .rd_data(rd_data),
    .loopback_en(loopback_en), .aneg_enable(aneg_enable), .aneg_restart(aneg_restart),
    .adv_word(adv_word), .cur_speed100(cur_speed100), .cur_full(cur_full),
    .mdix_auto(mdix_auto), .mdix_cross(mdix_cross)
  );

  assign led_100 = link_up & cur_speed100;
  assign led_10  = link_up & ~cur_speed100;
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mdio_oe,
  input logic        mdio_out,
  input logic        aneg_restart,
  input logic [15:0] adv_word,
  input logic        aneg_enable,
  input logic        cur_speed100,
  input logic        cur_full,
  input logic        neg_speed100,
  input logic        neg_full,
  input logic        link_up,
  input logic        led_10,
  input logic        led_100
);
  // R4
  restart_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aneg_restart |=> !aneg_restart);

  // R8
  adv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !aneg_restart |-> $stable(adv_word));

  // R1
  ta_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_out);

  // R3
  aneg_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aneg_enable |-> (cur_speed100 == neg_speed100) && (cur_full == neg_full));

  // R10
  led_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (led_10 || led_100) |-> link_up && !(led_10 && led_100));
endmodule

bind mdio_mgmt_slave mdio_mgmt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mdio_oe(mdio_oe), .mdio_out(mdio_out),
  .aneg_restart(aneg_restart), .adv_word(adv_word), .aneg_enable(aneg_enable),
  .cur_speed100(cur_speed100), .cur_full(cur_full), .neg_speed100(neg_speed100),
  .neg_full(neg_full), .link_up(link_up), .led_10(led_10), .led_100(led_100)
);

// File: tb/test_mdio_mgmt_slave.sv
`timescale 1ns/1ps
module test_mdio_mgmt_slave;
  localparam int          HALF = 20;
  localparam int          PRE  = 32;
  localparam logic [4:0]  MY_PHY = 5'h0B;
  localparam logic [15:0] ADVR = 16'h01E1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [2:0]  strap = 3'b001;
  logic        mdc = 1'b0;
  logic        m_en = 1'b0, m_bit = 1'b1;
  logic        link_up = 1'b0, neg_speed100 = 1'b0, neg_full = 1'b0;
  logic        mdio_out, mdio_oe, mdio_line;
  logic        loopback_en, aneg_enable, aneg_restart, cur_speed100, cur_full;
  logic        mdix_auto, mdix_cross, led_10, led_100;
  logic [15:0] adv_word;

  assign mdio_line = mdio_oe ? mdio_out : (m_en ? m_bit : 1'b1);

  mdio_mgmt_slave i_mdio_mgmt_slave (
    .clk(clk), .rst_n(rst_n), .phy_addr(MY_PHY), .strap(strap), .mdc(mdc),
    .mdio_in(mdio_line), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .link_up(link_up),
    .neg_speed100(neg_speed100), .neg_full(neg_full), .loopback_en(loopback_en),
    .aneg_enable(aneg_enable), .aneg_restart(aneg_restart), .adv_word(adv_word),
    .cur_speed100(cur_speed100), .cur_full(cur_full), .mdix_auto(mdix_auto),
    .mdix_cross(mdix_cross), .led_10(led_10), .led_100(led_100)
  );

  int errors = 0, checks = 0, pulses = 0, exp_pulses = 0;
  logic hold = 1'b1;

  // behavioural model state
  logic m_loop, m_spd, m_anen, m_dup, m_lat, m_auto, m_x;
  logic [15:0] m_anar, m_adv;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  function automatic logic e_spd();
    return m_anen ? neg_speed100 : m_spd;
  endfunction
  function automatic logic e_full();
    return m_anen ? neg_full : m_dup;
  endfunction

  // restart pulse counter and every-clock comparison
  always @(negedge clk) begin
    if (rst_n && aneg_restart) pulses++;
    if (rst_n && !hold) begin
      chk("R5 loopback_en", {15'd0, loopback_en}, {15'd0, m_loop});
      chk("R3 aneg_enable", {15'd0, aneg_enable}, {15'd0, m_anen});
      chk("R3 cur_speed100", {15'd0, cur_speed100}, {15'd0, e_spd()});
      chk("R3 cur_full", {15'd0, cur_full}, {15'd0, e_full()});
      chk("R10 led_100", {15'd0, led_100}, {15'd0, link_up & e_spd()});
      chk("R10 led_10", {15'd0, led_10}, {15'd0, link_up & ~e_spd()});
      chk("R9 mdix_auto", {15'd0, mdix_auto}, {15'd0, m_auto});
      chk("R9 mdix_cross", {15'd0, mdix_cross}, {15'd0, m_x});
      chk("R8 adv_word", adv_word, m_adv);
      chk("R1 idle oe", {15'd0, mdio_oe}, 16'd0);
      chk("R4 restart idle", {15'd0, aneg_restart}, 16'd0);
    end
  end

  task automatic do_reset(input logic [2:0] s);
    tick(); hold = 1'b1; rst_n = 1'b0; strap = s;
    repeat (4) tick();
    m_anen = s[0]; m_spd = s[1]; m_dup = s[2]; m_loop = 1'b0;
    m_anar = ADVR; m_adv = ADVR; m_lat = 1'b0; m_auto = 1'b1; m_x = 1'b0;
    rst_n = 1'b1;
    repeat (4) tick();
    hold = 1'b0;
  endtask

  task automatic mdc_bit(input logic b);
    m_bit = b;
    repeat (HALF) tick();
    mdc = 1'b1;
    repeat (HALF) tick();
    mdc = 1'b0;
  endtask

  task automatic send_hdr(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra);
    hold = 1'b1; m_en = 1'b1;
    repeat (PRE) mdc_bit(1'b1);
    mdc_bit(1'b0); mdc_bit(1'b1);
    for (int i = 1; i >= 0; i--) mdc_bit(op[i]);
    for (int i = 4; i >= 0; i--) mdc_bit(phy[i]);
    for (int i = 4; i >= 0; i--) mdc_bit(ra[i]);
  endtask

  task automatic do_write(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
    send_hdr(2'b01, phy, ra);
    mdc_bit(1'b1); mdc_bit(1'b0);
    for (int i = 15; i >= 0; i--) mdc_bit(d[i]);
    m_en = 1'b0; m_bit = 1'b1;
    repeat (12) tick();
    if (phy == MY_PHY) begin
      case (ra)
        5'h00: begin
          m_loop = d[14]; m_spd = d[13]; m_anen = d[12]; m_dup = d[8];
          if (d[9]) begin m_adv = m_anar; exp_pulses++; end
        end
        5'h04: m_anar = d;
        5'h12: begin m_auto = d[15]; m_x = d[14]; end
        default: ;
      endcase
    end
    chk("R4 restart pulse count", 16'(pulses), 16'(exp_pulses));
    hold = 1'b0;
  endtask

  function automatic logic [15:0] exp_rd(input logic [4:0] ra);
    case (ra)
      5'h00: return {1'b0, m_loop, m_spd, m_anen, 3'b000, m_dup, 8'h00};
      5'h01: return {13'd0, m_lat, 2'b00};
      5'h04: return m_anar;
      5'h11: return {12'd0, e_full(), link_up, e_spd(), 1'b0};
      5'h12: return {m_auto, m_x, 14'd0};
      default: return 16'h0000;
    endcase
  endfunction

  // performs a read and checks turnaround and data against the model
  task automatic do_read(input string tag, input logic [4:0] phy, input logic [4:0] ra);
    logic ta1, ta2;
    logic [15:0] got, exp;
    exp = (phy == MY_PHY) ? exp_rd(ra) : 16'hFFFF;
    send_hdr(2'b10, phy, ra);
    m_en = 1'b0;
    repeat (HALF) tick(); mdc = 1'b1; ta1 = mdio_line; repeat (HALF) tick(); mdc = 1'b0;
    repeat (HALF) tick(); mdc = 1'b1; ta2 = mdio_line; repeat (HALF) tick(); mdc = 1'b0;
    for (int i = 15; i >= 0; i--) begin
      repeat (HALF) tick(); mdc = 1'b1; got[i] = mdio_line; repeat (HALF) tick(); mdc = 1'b0;
    end
    repeat (12) tick();
    chk({tag, " R1 ta1 released"}, {15'd0, ta1}, 16'd1);
    chk({tag, " R1 ta2"}, {15'd0, ta2}, (phy == MY_PHY) ? 16'd0 : 16'd1);
    chk({tag, " data"}, got, exp);
    chk({tag, " R1 oe released"}, {15'd0, mdio_oe}, 16'd0);
    if (phy == MY_PHY && ra == 5'h01) m_lat = link_up;
    hold = 1'b0;
  endtask

  initial begin
    do_reset(3'b001);
    chk("R11 reset aneg", {15'd0, aneg_enable}, 16'd1);
    chk("R8 reset adv", adv_word, ADVR);
    do_read("R11 ctrl after strap 001", MY_PHY, 5'h00);
    do_read("R9 aux reset", MY_PHY, 5'h12);
    do_read("R8 adv reset", MY_PHY, 5'h04);
    tick(); link_up = 1'b1; neg_speed100 = 1'b1; neg_full = 1'b1;
    repeat (5) tick();
    do_read("R7 live mirror 100 full", MY_PHY, 5'h11);
    do_read("R6 first stat read low", MY_PHY, 5'h01);
    do_read("R6 second stat read up", MY_PHY, 5'h01);
    tick(); link_up = 1'b0; repeat (3) tick(); m_lat = 1'b0; link_up = 1'b1; repeat (3) tick();
    do_read("R6 stat after drop", MY_PHY, 5'h01);
    do_read("R6 stat recovered", MY_PHY, 5'h01);
    do_write(MY_PHY, 5'h04, 16'h0061);
    chk("R8 adv unchanged by write", adv_word, ADVR);
    do_read("R8 adv readback", MY_PHY, 5'h04);
    do_write(MY_PHY, 5'h00, 16'h1200);
    chk("R8 adv on restart", adv_word, 16'h0061);
    do_read("R4 restart self clear", MY_PHY, 5'h00);
    tick(); neg_speed100 = 1'b0; neg_full = 1'b0; repeat (3) tick();
    do_write(MY_PHY, 5'h00, 16'h6100);
    chk("R3 forced 100", {15'd0, cur_speed100}, 16'd1);
    chk("R10 led_100 forced", {15'd0, led_100}, 16'd1);
    do_read("R7 live forced", MY_PHY, 5'h11);
    do_write(MY_PHY, 5'h00, 16'h0000);
    chk("R10 led_10 forced", {15'd0, led_10}, 16'd1);
    do_write(MY_PHY, 5'h12, 16'h4000);
    do_read("R9 aux written", MY_PHY, 5'h12);
    do_write(5'h03, 5'h00, 16'h5100);
    do_read("R2 ctrl unchanged", MY_PHY, 5'h00);
    do_read("R2 foreign read", 5'h03, 5'h00);
    do_write(MY_PHY, 5'h11, 16'hFFFF);
    do_write(MY_PHY, 5'h05, 16'hFFFF);
    do_write(MY_PHY, 5'h01, 16'hFFFF);
    do_read("R12 unmapped", MY_PHY, 5'h05);
    do_read("R12 live ro", MY_PHY, 5'h11);
    do_read("R12 stat ro", MY_PHY, 5'h01);
    do_reset(3'b110);
    do_read("R11 strap 110", MY_PHY, 5'h00);
    do_reset(3'b010);
    chk("R11 strap 010 speed", {15'd0, cur_speed100}, 16'd1);
    chk("R11 strap 010 duplex", {15'd0, cur_full}, 16'd0);
    do_reset(3'b100);
    chk("R11 strap 100 speed", {15'd0, cur_speed100}, 16'd0);
    chk("R11 strap 100 duplex", {15'd0, cur_full}, 16'd1);
    repeat (10) tick();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule